// File: doc/BRIEF.md
# Endian-Aware Bus-Matching Width Converter

This block sits between a 36-bit long-word datapath and a port that runs at one of three widths. On the narrow port, a long word is either four 9-bit byte lanes, two 18-bit word halves, or the whole 36-bit word. The block works in both directions at once. The split path accepts a long word and emits its pieces one per handshake. The join path accepts pieces and emits the long word they form. Both paths hold their data through stalls on the far side.

Two settings are sampled on every clock while reset is held, and they are frozen once reset is released:

- the bus-size code;
- the piece-ordering bit (high = most significant piece first).

Changing the setting inputs at any other time does nothing. At full width the data passes through unchanged and the ordering bit plays no part. On the narrow port, a piece always travels in the low bits of the 36-bit bus.

Top module: `lw_width_adapter`

## Requirements
- R1: While `rst` is high, `wide_in_ready` and `nar_in_ready` are low. In the first cycle after reset, `nar_out_valid` and `wide_out_valid` are low.
- R2: Splitting with the ordering bit high sends the most significant lane first and the least significant lane last. In byte mode the lanes go [35:27], [26:18], [17:9], [8:0]. In word mode they go [35:18], [17:0]. Each piece is placed in the low bits of `nar_out_data`, and all bits above it are zero.
- R3: Splitting with the ordering bit low sends the lanes in the opposite order, starting with [8:0] in byte mode and [17:0] in word mode.
- R4: Joining with the ordering bit high places the first piece received in the most significant lane of `wide_out_data`, and each later piece in the next lower lane.
- R5: Joining with the ordering bit low places the first piece received in lane [8:0] (byte mode) or [17:0] (word mode), and each later piece in the next higher lane.
- R6: When a sink stalls, an output with valid high keeps its data and its valid until accepted. Across any stall pattern, no piece or word is dropped or repeated.
- R7: `wide_out_valid` rises only after the last piece of a word has been accepted. In narrow modes, the bits of `nar_in_data` above the piece width have no effect on `wide_out_data`.
- R8: The bus-size code is 2'b00 for full width, 2'b01 for word mode and 2'b10 for byte mode; 2'b11 also means full width. At full width, each word passes unchanged in both directions with one handshake per word, whatever the ordering bit is.
- R9: Values on `order_msb_first` and `size_code` while `rst` is low do not change the ordering or the piece count in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the settings are sampled while it is high |
| order_msb_first | input | 1 | Piece ordering: 1 = most significant piece first |
| size_code | input | 2 | Narrow port width code |
| wide_in_data | input | 36 | Long word to split |
| wide_in_valid | input | 1 | Long word offered |
| wide_in_ready | output | 1 | Split path can take a long word |
| nar_out_data | output | 36 | Piece, in the low bits |
| nar_out_valid | output | 1 | Piece offered |
| nar_out_ready | input | 1 | Sink takes the piece |
| nar_in_data | input | 36 | Piece to join, in the low bits |
| nar_in_valid | input | 1 | Piece offered |
| nar_in_ready | output | 1 | Join path can take a piece |
| wide_out_data | output | 36 | Joined long word |
| wide_out_valid | output | 1 | Joined long word offered |
| wide_out_ready | input | 1 | Sink takes the long word |

## Verification
The bench uses the default parameters: four 9-bit lanes, which gives a 36-bit long word. This keeps all four size codes and both ordering values within a sweep of eight short runs. Each run streams a dozen words through both paths at once. The ready lines on both sinks, and the valid line on the piece input, follow fixed stall patterns with different periods. This makes back-to-back transfers, single-cycle stalls and long stalls all occur, including on the last piece of a word. During each run the bench drives the opposite setting values, so any setting that leaks in outside reset changes the order of the output pieces or words.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  typedef enum logic [1:0] {
    SZ_FULL = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_ALT  = 2'b11
  } size_e;
endpackage

// File: rtl/lwa_cfg.sv
module lwa_cfg
  import lwa_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          order_in,
  input  logic [1:0]    size_in,
  output logic          msb_first,
  output size_e         size,
  output logic [IW-1:0] last_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      msb_first <= order_in;
      size      <= size_e'(size_in);
    end
  end

  always_comb begin
    case (size)
      SZ_BYTE: last_idx = IW'(LANES - 1);
      SZ_WORD: last_idx = IW'(LANES / 2 - 1);
      default: last_idx = '0;
    endcase
  end
endmodule

// File: rtl/lwa_split.sv
module lwa_split
  import lwa_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WW = LANE_W * LANES,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          msb_first,
  input  size_e         size,
  input  logic [IW-1:0] last_idx,
  input  logic [WW-1:0] w_data,
  input  logic          w_valid,
  output logic          w_ready,
  output logic [WW-1:0] n_data,
  output logic          n_valid,
  input  logic          n_ready
);
  logic          busy;
  logic [IW-1:0] k;
  logic [WW-1:0] hold;
  logic [IW-1:0] lane;
  logic          at_last;

  function automatic logic [WW-1:0] pick(logic [WW-1:0] w, size_e s, logic [IW-1:0] ln);
    logic [WW-1:0] r;
    r = '0;
    case (s)
      SZ_BYTE: r[LANE_W-1:0]   = w[ln*LANE_W +: LANE_W];
      SZ_WORD: r[2*LANE_W-1:0] = w[ln*2*LANE_W +: 2*LANE_W];
      default: r = w;
    endcase
    return r;
  endfunction

  assign at_last = (k == last_idx);
  assign lane    = msb_first ? (last_idx - k) : k;
  assign w_ready = !rst && (!busy || (at_last && n_ready));
  assign n_valid = busy;
  assign n_data  = pick(hold, size, lane);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      k    <= '0;
      hold <= '0;
    end else begin
      if (busy && n_ready) k <= at_last ? '0 : k + 1'b1;
      if (w_valid && w_ready) begin
        hold <= w_data;
        busy <= 1'b1;
      end else if (busy && n_ready && at_last) begin
        busy <= 1'b0;
      end
    end
  end

  assert_hold_piece_R6: assert property (@(posedge clk) disable iff (rst)
    n_valid && !n_ready |=> n_valid && $stable(n_data));
  assert_piece_needs_word_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(n_valid) |-> $past(w_valid && w_ready));
  always_comb begin
    if (rst) assert_ready_low_in_reset_R1: assert (!w_ready);
  end
endmodule

// File: rtl/lwa_join.sv
module lwa_join
  import lwa_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WW = LANE_W * LANES,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          msb_first,
  input  size_e         size,
  input  logic [IW-1:0] last_idx,
  input  logic [WW-1:0] n_data,
  input  logic          n_valid,
  output logic          n_ready,
  output logic [WW-1:0] w_data,
  output logic          w_valid,
  input  logic          w_ready
);
  logic [IW-1:0] k;
  logic [WW-1:0] acc;
  logic [WW-1:0] merged;
  logic [IW-1:0] lane;
  logic          fire;
  logic          at_last;

  function automatic logic [WW-1:0] place(logic [WW-1:0] base, size_e s,
                                          logic [IW-1:0] ln, logic [WW-1:0] p);
    logic [WW-1:0] r;
    r = base;
    case (s)
      SZ_BYTE: r[ln*LANE_W +: LANE_W]     = p[LANE_W-1:0];
      SZ_WORD: r[ln*2*LANE_W +: 2*LANE_W] = p[2*LANE_W-1:0];
      default: r = p;
    endcase
    return r;
  endfunction

  assign at_last = (k == last_idx);
  assign lane    = msb_first ? (last_idx - k) : k;
  assign n_ready = !rst && (!w_valid || w_ready);
  assign fire    = n_valid && n_ready;
  assign merged  = place(acc, size, lane, n_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      k       <= '0;
      acc     <= '0;
      w_data  <= '0;
      w_valid <= 1'b0;
    end else begin
      if (w_valid && w_ready) w_valid <= 1'b0;
      if (fire) begin
        if (at_last) begin
          w_data  <= merged;
          w_valid <= 1'b1;
          k       <= '0;
          acc     <= '0;
        end else begin
          acc <= merged;
          k   <= k + 1'b1;
        end
      end
    end
  end

  assert_hold_word_R6: assert property (@(posedge clk) disable iff (rst)
    w_valid && !w_ready |=> w_valid && $stable(w_data));
  assert_word_after_piece_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(w_valid) |-> $past(n_valid && n_ready));
  always_comb begin
    if (rst) assert_join_ready_low_R1: assert (!n_ready);
  end
endmodule

// File: rtl/lw_width_adapter.sv
module lw_width_adapter
  import lwa_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WW = LANE_W * LANES,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          order_msb_first,
  input  logic [1:0]    size_code,
  input  logic [WW-1:0] wide_in_data,
  input  logic          wide_in_valid,
  output logic          wide_in_ready,
  output logic [WW-1:0] nar_out_data,
  output logic          nar_out_valid,
  input  logic          nar_out_ready,
  input  logic [WW-1:0] nar_in_data,
  input  logic          nar_in_valid,
  output logic          nar_in_ready,
  output logic [WW-1:0] wide_out_data,
  output logic          wide_out_valid,
  input  logic          wide_out_ready
);
  logic          msb_first;
  size_e         size;
  logic [IW-1:0] last_idx;

  lwa_cfg #(.LANES(LANES)) u_cfg (
    .clk(clk), .rst(rst), .order_in(order_msb_first), .size_in(size_code),
    .msb_first(msb_first), .size(size), .last_idx(last_idx)
  );

  lwa_split #(.LANE_W(LANE_W), .LANES(LANES)) u_split (
    .clk(clk), .rst(rst), .msb_first(msb_first), .size(size), .last_idx(last_idx),
    .w_data(wide_in_data), .w_valid(wide_in_valid), .w_ready(wide_in_ready),
    .n_data(nar_out_data), .n_valid(nar_out_valid), .n_ready(nar_out_ready)
  );

  lwa_join #(.LANE_W(LANE_W), .LANES(LANES)) u_join (
    .clk(clk), .rst(rst), .msb_first(msb_first), .size(size), .last_idx(last_idx),
    .n_data(nar_in_data), .n_valid(nar_in_valid), .n_ready(nar_in_ready),
    .w_data(wide_out_data), .w_valid(wide_out_valid), .w_ready(wide_out_ready)
  );
endmodule

// File: tb/lw_width_adapter_test.sv
`timescale 1ns/1ps
module lw_width_adapter_test;
  localparam int WW = 36;
  localparam int NW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic order_msb_first = 1'b0;
  logic [1:0] size_code = 2'b00;
  logic [WW-1:0] wide_in_data = '0;
  logic wide_in_valid = 1'b0;
  logic wide_in_ready;
  logic [WW-1:0] nar_out_data;
  logic nar_out_valid;
  logic nar_out_ready = 1'b0;
  logic [WW-1:0] nar_in_data = '0;
  logic nar_in_valid = 1'b0;
  logic nar_in_ready;
  logic [WW-1:0] wide_out_data;
  logic wide_out_valid;
  logic wide_out_ready = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lw_width_adapter uut (
    .clk(clk), .rst(rst), .order_msb_first(order_msb_first), .size_code(size_code),
    .wide_in_data(wide_in_data), .wide_in_valid(wide_in_valid), .wide_in_ready(wide_in_ready),
    .nar_out_data(nar_out_data), .nar_out_valid(nar_out_valid), .nar_out_ready(nar_out_ready),
    .nar_in_data(nar_in_data), .nar_in_valid(nar_in_valid), .nar_in_ready(nar_in_ready),
    .wide_out_data(wide_out_data), .wide_out_valid(wide_out_valid), .wide_out_ready(wide_out_ready)
  );

  task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] wgen(int c, int i);
    longint v;
    v = (longint'(i + 1) * 40503 + longint'(c) * 977) * 64'd2654435761;
    return WW'(v ^ (v >> 29));
  endfunction

  function automatic int npieces(int sz);
    return (sz == 2) ? 4 : (sz == 1) ? 2 : 1;
  endfunction

  function automatic int pwidth(int sz);
    return (sz == 2) ? 9 : (sz == 1) ? 18 : 36;
  endfunction

  function automatic logic [WW-1:0] piece_of(logic [WW-1:0] w, int sz, int be, int k);
    int np = npieces(sz);
    int pw = pwidth(sz);
    int ln = be ? (np - 1 - k) : k;
    logic [WW-1:0] m;
    if (np == 1) return w;
    m = (WW'(1) << pw) - 1;
    return (w >> (ln * pw)) & m;
  endfunction

  task automatic run_cfg(int c, int sz, int be);
    int np = npieces(sz);
    int si = 0, po = 0, pi = 0, wo = 0;
    string sreq, jreq;
    if (np == 1) begin sreq = "R8"; jreq = "R8"; end
    else if (be != 0) begin sreq = "R2"; jreq = "R4"; end
    else begin sreq = "R3"; jreq = "R5"; end
    @(negedge clk);
    rst = 1'b1;
    order_msb_first = be[0];
    size_code = sz[1:0];
    wide_in_valid = 1'b0; nar_in_valid = 1'b0;
    nar_out_ready = 1'b0; wide_out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in_ready in reset", {35'd0, wide_in_ready}, '0);
    chk("R1 nar_in_ready in reset", {35'd0, nar_in_ready}, '0);
    rst = 1'b0;
    // R9: drive opposite settings once out of reset
    order_msb_first = ~be[0];
    size_code = (sz == 2) ? 2'b01 : 2'b10;
    @(negedge clk);
    chk("R1 nar_out_valid after reset", {35'd0, nar_out_valid}, '0);
    chk("R1 wide_out_valid after reset", {35'd0, wide_out_valid}, '0);
    for (int cy = 0; cy < 2000 && !(wo == NW && po == NW * np); cy++) begin
      wide_in_valid  = (si < NW);
      wide_in_data   = wgen(c, si);
      nar_out_ready  = ((cy % 5) != 2) && ((cy % 13) < 9);
      nar_in_valid   = (pi < NW * np) && ((cy % 7) != 3);
      nar_in_data    = piece_of(wgen(c, pi / np), sz, be, pi % np);
      if (np > 1) nar_in_data = nar_in_data | (WW'(36'h5A5A5A5A5) << pwidth(sz));
      wide_out_ready = ((cy % 3) != 1) && ((cy % 11) < 7);
      #1;
      if (wide_out_valid) chk("R7 word only after last piece", {35'd0, (pi >= (wo + 1) * np)}, 36'd1);
      if (wide_in_valid && wide_in_ready) si++;
      if (nar_out_valid && nar_out_ready) begin
        if (po < NW * np) chk(sreq, nar_out_data, piece_of(wgen(c, po / np), sz, be, po % np));
        else chk("R6 extra piece", 36'd1, 36'd0);
        po++;
      end
      if (nar_in_valid && nar_in_ready) pi++;
      if (wide_out_valid && wide_out_ready) begin
        if (wo < NW) chk(jreq, wide_out_data, wgen(c, wo));
        else chk("R6 extra word", 36'd1, 36'd0);
        wo++;
      end
      @(negedge clk);
    end
    chk("R6 piece count", 36'(po), 36'(NW * np));
    chk("R6 word count", 36'(wo), 36'(NW));
    wide_in_valid = 1'b0;
    nar_in_valid = 1'b0;
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int c = 0;
    for (int sz = 0; sz < 4; sz++) begin
      for (int be = 0; be < 2; be++) begin
        run_cfg(c, sz, be);
        c++;
      end
    end
    report();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        report();
      end
    end
  end
endmodule